// File: doc/BRIEF.md
# Self-Detecting Serial Audio Frame Receiver

This block turns a three-wire serial audio stream (bit clock, word select, serial data) into parallel left and right samples. The three lines are brought into the system clock domain by synchronizer chains. Each rising edge of the bit clock is detected there and used to take one data bit, MSB first. The receiver counts the bit clocks between word-select transitions. From that count it decides whether the stream carries 16-bit or 32-bit slots, so no setting is needed for the word length.

Two static control inputs adapt the receiver to the variants of the format. One chooses which level of word select marks the left channel. The other chooses whether the MSB follows the word-select transition by one bit clock or arrives on the same clock. Each completed frame (a left slot followed by a right slot) gives one pair of 32-bit, left-justified words and a one-cycle strobe. A level output reports the detected slot width, and a pulse marks any slot whose length is neither 16 nor 32.

Top module: `i2s_rx_auto`

## Requirements
- R1: Data is taken on rising edges of `sck`, MSB first. With 32-bit slots the 32 bits of a slot appear unchanged in the output word, and the first bit received lands in bit 31.
- R2: With 16-bit slots, the 16 received bits occupy bits 31..16 of the output word and bits 15..0 are zero.
- R3: A slot of exactly 16 bit clocks selects short mode and one of exactly 32 selects long mode. `mode_long` is 0 for short mode and 1 for long mode.
- R4: A slot of any other length pulses `fmt_err` for one cycle and leaves `mode_long` unchanged. The frame containing that slot produces no strobe.
- R5: With `ws_pol` = 0, the slot sent while `ws` is low is the left channel and the slot sent while `ws` is high is the right channel.
- R6: With `ws_pol` = 1, the roles are swapped: `ws` high marks left and `ws` low marks right.
- R7: With `dly_en` = 1, the MSB of a slot is the bit taken one `sck` rising edge after the edge that first sees the new `ws` level.
- R8: With `dly_en` = 0, the MSB of a slot is the bit taken on the same `sck` rising edge that first sees the new `ws` level.
- R9: `frame_valid` pulses high for exactly one cycle per complete left-then-right frame. The pulse comes once the right slot has been closed by the next `ws` transition, and `left`/`right` hold that frame's words from then on.
- R10: If a slot changes the detected mode, `mode_long` follows the new mode and the frame containing that slot produces no strobe.
- R11: After reset, `frame_valid`, `fmt_err` and `mode_long` are 0 and `left` and `right` are zero. The first `ws` transition seen after reset only starts the count, so the partial slot before it is discarded.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial lines |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck | input | 1 | Serial bit clock |
| ws | input | 1 | Word select (channel identification) |
| sd | input | 1 | Serial data |
| ws_pol | input | 1 | 0: ws low is left; 1: ws high is left |
| dly_en | input | 1 | 1: MSB one bit clock after the ws transition; 0: on the same clock |
| left | output | 32 | Left sample, left-justified |
| right | output | 32 | Right sample, left-justified |
| frame_valid | output | 1 | One-cycle strobe for a new sample pair |
| mode_long | output | 1 | Detected slot width: 0 = 16 bits, 1 = 32 bits |
| fmt_err | output | 1 | One-cycle pulse on a slot of unsupported length |

## Verification
The assertions check four rules on every cycle. The strobe is a single-cycle pulse that only follows a bit-clock edge. A length error never coincides with a strobe and never moves the mode flag. A mode change never coincides with a strobe, and short-mode words always carry zero low halves. What only the bench's scenarios can show is that the words are correct: the bit order, the channel assignment under both polarities and both delay settings, and which frames are dropped around a length error or a mode switch. For this, the bench serializes known words and compares them against a model of the frame-acceptance rules.

// File: rtl/i2s_rx_pkg.sv
package i2s_rx_pkg;
    typedef enum logic {
        MODE_SHORT = 1'b0,
        MODE_LONG  = 1'b1
    } slot_mode_e;

    localparam int DEF_SHORT_BITS = 16;
    localparam int DEF_LONG_BITS  = 32;
    localparam int DEF_SYNC_STAGES = 2;
endpackage

// File: rtl/i2s_rx_sync.sv
module i2s_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck,
    input  logic ws,
    input  logic sd,
    output logic ws_s,
    output logic sd_s,
    output logic bit_stb
);
    localparam int W = 3;

    logic [W-1:0] stage_q [STAGES];
    logic         sck_last_q;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    stage_q[g] <= '0;
                end else if (g == 0) begin
                    stage_q[g] <= {sck, ws, sd};
                end else begin
                    stage_q[g] <= stage_q[(g == 0) ? 0 : g - 1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_last_q <= 1'b0;
        end else begin
            sck_last_q <= stage_q[STAGES-1][2];
        end
    end

    assign ws_s    = stage_q[STAGES-1][1];
    assign sd_s    = stage_q[STAGES-1][0];
    assign bit_stb = stage_q[STAGES-1][2] & ~sck_last_q;
endmodule

// File: rtl/i2s_rx_deser.sv
module i2s_rx_deser
    import i2s_rx_pkg::*;
#(
    parameter int SHORT_BITS = DEF_SHORT_BITS,
    parameter int LONG_BITS  = DEF_LONG_BITS
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bit_stb,
    input  logic                 ws,
    input  logic                 sd,
    input  logic                 ws_pol,
    input  logic                 dly_en,
    output logic [LONG_BITS-1:0] left,
    output logic [LONG_BITS-1:0] right,
    output logic                 frame_valid,
    output logic                 mode_long,
    output logic                 fmt_err
);
    localparam int CW  = $clog2(LONG_BITS * 2) + 1;
    localparam int PAD = LONG_BITS - SHORT_BITS;

    typedef struct packed {
        logic [1:0]           warm;
        logic                 ws_p;
        logic                 wsl;
        logic [CW-1:0]        cnt;
        logic [LONG_BITS-1:0] sh;
        logic [LONG_BITS-1:0] lhold;
        logic                 lok;
        slot_mode_e           mode;
        logic [LONG_BITS-1:0] lout;
        logic [LONG_BITS-1:0] rout;
        logic                 valid;
        logic                 err;
    } st_t;

    st_t st_d, st_q;

    logic                 ws_eff_d;
    logic                 edge_d;
    logic                 good_s_d;
    logic                 good_l_d;
    logic                 is_right_d;
    logic                 half_ok_d;
    logic [LONG_BITS-1:0] word_d;

    always_comb begin
        st_d        = st_q;
        st_d.valid  = 1'b0;
        st_d.err    = 1'b0;
        ws_eff_d    = dly_en ? st_q.ws_p : ws;
        edge_d      = (ws_eff_d != st_q.wsl);
        good_s_d    = (st_q.cnt == CW'(SHORT_BITS));
        good_l_d    = (st_q.cnt == CW'(LONG_BITS));
        is_right_d  = st_q.wsl ^ ws_pol;
        word_d      = good_l_d ? st_q.sh : {st_q.sh[SHORT_BITS-1:0], {PAD{1'b0}}};
        half_ok_d   = 1'b0;

        if (bit_stb) begin
            st_d.ws_p = ws;
            st_d.wsl  = ws_eff_d;
            if (st_q.warm != 2'd3) begin
                // discard the partial slot seen before the first transition
                if (st_q.warm != 2'd2 || edge_d) begin
                    st_d.warm = st_q.warm + 2'd1;
                end
                st_d.cnt = CW'(1);
                st_d.sh  = LONG_BITS'(sd);
            end else if (edge_d) begin
                if (!(good_s_d || good_l_d)) begin
                    st_d.err  = 1'b1;
                    half_ok_d = 1'b0;
                end else begin
                    st_d.mode = good_l_d ? MODE_LONG : MODE_SHORT;
                    half_ok_d = (st_d.mode == st_q.mode);
                end
                if (!is_right_d) begin
                    st_d.lhold = word_d;
                    st_d.lok   = half_ok_d;
                end else begin
                    if (st_q.lok && half_ok_d) begin
                        st_d.valid = 1'b1;
                        st_d.lout  = st_q.lhold;
                        st_d.rout  = word_d;
                    end
                    st_d.lok = 1'b0;
                end
                st_d.cnt = CW'(1);
                st_d.sh  = LONG_BITS'(sd);
            end else begin
                if (st_q.cnt != {CW{1'b1}}) begin
                    st_d.cnt = st_q.cnt + CW'(1);
                end
                st_d.sh = {st_q.sh[LONG_BITS-2:0], sd};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.mode <= MODE_SHORT;
        end else begin
            st_q <= st_d;
        end
    end

    assign left        = st_q.lout;
    assign right       = st_q.rout;
    assign frame_valid = st_q.valid;
    assign mode_long   = (st_q.mode == MODE_LONG);
    assign fmt_err     = st_q.err;
endmodule

// File: rtl/i2s_rx_auto.sv
module i2s_rx_auto
    import i2s_rx_pkg::*;
#(
    parameter int SHORT_BITS  = DEF_SHORT_BITS,
    parameter int LONG_BITS   = DEF_LONG_BITS,
    parameter int SYNC_STAGES = DEF_SYNC_STAGES
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sck,
    input  logic                 ws,
    input  logic                 sd,
    input  logic                 ws_pol,
    input  logic                 dly_en,
    output logic [LONG_BITS-1:0] left,
    output logic [LONG_BITS-1:0] right,
    output logic                 frame_valid,
    output logic                 mode_long,
    output logic                 fmt_err
);
    logic ws_s;
    logic sd_s;
    logic bit_stb;

    i2s_rx_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .sck     (sck),
        .ws      (ws),
        .sd      (sd),
        .ws_s    (ws_s),
        .sd_s    (sd_s),
        .bit_stb (bit_stb)
    );

    i2s_rx_deser #(
        .SHORT_BITS (SHORT_BITS),
        .LONG_BITS  (LONG_BITS)
    ) u_deser (
        .clk         (clk),
        .rst_n       (rst_n),
        .bit_stb     (bit_stb),
        .ws          (ws_s),
        .sd          (sd_s),
        .ws_pol      (ws_pol),
        .dly_en      (dly_en),
        .left        (left),
        .right       (right),
        .frame_valid (frame_valid),
        .mode_long   (mode_long),
        .fmt_err     (fmt_err)
    );
endmodule

// File: rtl/i2s_rx_auto_chk.sv
module i2s_rx_auto_chk #(
    parameter int SHORT_BITS = 16,
    parameter int LONG_BITS  = 32
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 bit_stb,
    input logic [LONG_BITS-1:0] left,
    input logic [LONG_BITS-1:0] right,
    input logic                 frame_valid,
    input logic                 mode_long,
    input logic                 fmt_err
);
    localparam int PAD = LONG_BITS - SHORT_BITS;

    a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        frame_valid |=> !frame_valid);

    a_r9_after_bit_edge: assert property (@(posedge clk) disable iff (!rst_n)
        frame_valid |-> $past(bit_stb));

    a_r4_err_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        fmt_err |-> !frame_valid);

    a_r4_err_keeps_mode: assert property (@(posedge clk) disable iff (!rst_n)
        fmt_err |-> $stable(mode_long));

    a_r10_switch_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_long != $past(mode_long)) |-> !frame_valid);

    a_r2_short_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_valid && !mode_long) |-> (left[PAD-1:0] == '0 && right[PAD-1:0] == '0));
endmodule

bind i2s_rx_auto i2s_rx_auto_chk #(
    .SHORT_BITS (SHORT_BITS),
    .LONG_BITS  (LONG_BITS)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bit_stb     (bit_stb),
    .left        (left),
    .right       (right),
    .frame_valid (frame_valid),
    .mode_long   (mode_long),
    .fmt_err     (fmt_err)
);

// File: tb/sim_i2s_rx_auto.sv
`timescale 1ns/1ps
module sim_i2s_rx_auto;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sck = 1'b0;
    logic        ws = 1'b0;
    logic        sd = 1'b0;
    logic        ws_pol = 1'b0;
    logic        dly_en = 1'b0;
    logic [31:0] left, right;
    logic        frame_valid, mode_long, fmt_err;

    always #2.5 clk = ~clk;

    i2s_rx_auto u0 (
        .clk(clk), .rst_n(rst_n), .sck(sck), .ws(ws), .sd(sd),
        .ws_pol(ws_pol), .dly_en(dly_en), .left(left), .right(right),
        .frame_valid(frame_valid), .mode_long(mode_long), .fmt_err(fmt_err)
    );

    int checks = 0;
    int fails = 0;
    bit done = 0;

    int          nfr;
    int          fl_len [16];
    int          fr_len [16];
    logic [31:0] fl_dat [16];
    logic [31:0] fr_dat [16];

    logic [31:0] cap_l [64];
    logic [31:0] cap_r [64];
    int          cap_n = 0;
    int          err_n = 0;
    int          dbl_n = 0;
    logic        prev_v = 1'b0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (frame_valid) begin
                if (cap_n < 64) begin
                    cap_l[cap_n] = left;
                    cap_r[cap_n] = right;
                end
                if (prev_v) dbl_n++;
                cap_n++;
            end
            if (fmt_err) err_n++;
            prev_v = frame_valid;
        end
    end

    function automatic logic [31:0] exp_word(input int n, input logic [31:0] d);
        return (n == 16) ? {d[31:16], 16'h0000} : d;
    endfunction

    task automatic check(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic send_bit(input logic w, input logic b);
        @(negedge clk);
        sck = 1'b0; ws = w; sd = b;
        repeat (4) @(negedge clk);
        sck = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic send_half(input logic w, input logic [31:0] d, input int n, input logic dly);
        for (int i = 0; i < n; i++) begin
            send_bit((dly && i == n - 1) ? ~w : w, d[31 - i]);
        end
    endtask

    task automatic run_block(input logic p, input logic dly, input string req);
        logic [31:0] el [16];
        logic [31:0] er [16];
        int   en = 0, eerr = 0;
        logic emode = 1'b0;
        rst_n = 1'b0; ws_pol = p; dly_en = dly; ws = ~p; sck = 1'b0;
        repeat (4) @(negedge clk);
        cap_n = 0; err_n = 0; dbl_n = 0; prev_v = 1'b0;
        rst_n = 1'b1;
        send_half(~p, 32'h0, 3, dly);
        for (int f = 0; f < nfr; f++) begin
            send_half(p, fl_dat[f], fl_len[f], dly);
            send_half(~p, fr_dat[f], fr_len[f], dly);
        end
        send_bit(p, 1'b0);
        send_bit(p, 1'b0);
        repeat (10) @(negedge clk);
        // model of slot acceptance: bad length or mode switch drops the frame
        for (int f = 0; f < nfr; f++) begin
            bit ok = 1;
            for (int h = 0; h < 2; h++) begin
                int n = (h == 0) ? fl_len[f] : fr_len[f];
                if (n != 16 && n != 32) begin
                    eerr++; ok = 0;
                end else if ((n == 32) != emode) begin
                    emode = (n == 32); ok = 0;
                end
            end
            if (ok) begin
                el[en] = exp_word(fl_len[f], fl_dat[f]);
                er[en] = exp_word(fr_len[f], fr_dat[f]);
                en++;
            end
        end
        check({req, " R9"}, "strobe count", 64'(cap_n), 64'(en));
        check("R9", "double-cycle strobes", 64'(dbl_n), 64'd0);
        check("R4", "error pulses", 64'(err_n), 64'(eerr));
        check("R3", "mode flag", 64'(mode_long), 64'(emode));
        for (int i = 0; i < en && i < cap_n; i++) begin
            check(req, $sformatf("frame %0d words", i), {cap_l[i], cap_r[i]}, {el[i], er[i]});
        end
    endtask

    initial begin
        #(150000 * 5);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        // R11: reset state
        check("R11", "reset outputs", {30'h0, frame_valid, fmt_err, mode_long, left[0], right[0]}, 64'h0);
        check("R11", "reset words", {left, right}, 64'h0);

        // short slots, polarity 0, delayed MSB
        nfr = 6;
        for (int f = 0; f < nfr; f++) begin
            fl_len[f] = 16; fr_len[f] = 16;
            fl_dat[f] = $urandom(); fr_dat[f] = $urandom();
        end
        fl_dat[0] = 32'h8001_0000; fr_dat[0] = 32'h0001_0000;
        run_block(1'b0, 1'b1, "R2 R5 R7");

        // long slots, polarity 1, no delay; first frame dropped by the switch
        nfr = 5;
        for (int f = 0; f < nfr; f++) begin
            fl_len[f] = 32; fr_len[f] = 32;
            fl_dat[f] = $urandom(); fr_dat[f] = $urandom();
        end
        fl_dat[1] = 32'h8000_0000; fr_dat[1] = 32'h0000_0001;
        fl_dat[2] = 32'hA5C3_0F01; fr_dat[2] = 32'hFFFF_FFFE;
        run_block(1'b1, 1'b0, "R1 R3 R6 R8 R10");

        // length error inside long mode, then a switch back to short mode
        nfr = 6;
        for (int f = 0; f < nfr; f++) begin
            fl_len[f] = (f < 3) ? 32 : 16; fr_len[f] = fl_len[f];
            fl_dat[f] = $urandom(); fr_dat[f] = $urandom();
        end
        fl_len[2] = 24;
        run_block(1'b0, 1'b0, "R4 R10");

        // long slots, polarity 1, delayed MSB
        nfr = 4;
        for (int f = 0; f < nfr; f++) begin
            fl_len[f] = 32; fr_len[f] = 32;
            fl_dat[f] = $urandom(); fr_dat[f] = $urandom();
        end
        run_block(1'b1, 1'b1, "R1 R6 R7");

        // random mixes of lengths, polarity and delay
        for (int b = 0; b < 6; b++) begin
            nfr = 5 + ($urandom() % 4);
            for (int f = 0; f < nfr; f++) begin
                int r = $urandom() % 10;
                fl_len[f] = (r == 0) ? 20 : ((r < 5) ? 16 : 32);
                fr_len[f] = (($urandom() % 8) == 0) ? 33 - (fl_len[f] / 16) * 16 + 15 : fl_len[f];
                fl_dat[f] = $urandom(); fr_dat[f] = $urandom();
            end
            run_block(1'($urandom()), 1'($urandom()), "R1 R2 R3 R4 R5 R6 R7 R8 R10");
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule